// File: doc/BRIEF.md
# Background Distance-Map Encoder

This block sits in a tile solver core. After a first pass of solver iterations that visits every pixel of a tile, the core streams the tile's per-pixel flow vectors (du, dv) through this encoder in raster order. The encoder classifies each pixel as moving or as background. Background pixels are dropped from the later iterations. The set of pixels that remain active is written to a small distance-map register file as run lengths. Each entry is the distance from the previous active pixel, so the second phase can step from one active pixel to the next without keeping a bitmask or full addresses.

The motion test uses a cheap magnitude, |du| + |dv|, compared against a threshold that software loads. A pixel whose magnitude is at or above the threshold survives. Each row of the tile is closed by a zero entry. If the map cannot hold every entry, the surplus is dropped and a flag tells the second phase to process every pixel instead. Two write lanes let a surviving last-column pixel and its row terminator be stored on the same edge, so the input stream never has to stall.

Top module: `bgd_dist_encoder`

## Requirements
- R1: A pixel's magnitude is |du| + |dv| with du and dv taken as two's complement, computed without loss (the most negative value counts as its full size). The pixel survives when the magnitude is greater than or equal to `threshold`, so a threshold of 0 keeps every pixel.
- R2: A background pixel (magnitude below threshold) writes no entry and adds one to the pending gap.
- R3: A surviving pixel writes one entry of value gap + 1 on lane 0, at the next free map address (addresses rise from 0 with no holes), and clears the gap.
- R4: An entry whose value gap + 1 exceeds 2^ENTRY_W − 1 is stored as 2^ENTRY_W − 1.
- R5: The pixel in the last column (index TILE_W − 1) of every row is followed by an entry of value 0 on lane 1. Its address is one past the lane-0 entry of the same pixel, if there is one. The gap is cleared at every row end.
- R6: No address at or above MAP_DEPTH is written. Entries that do not fit are dropped, and `overflow` rises and stays high until the next `start`.
- R7: `done` is high for exactly one cycle. It rises on the edge that stores the entries of the tile's TILE_W × TILE_H-th accepted pixel. Pixels offered after that edge and before the next `start` write nothing.
- R8: `start` clears the write address, the gap and `overflow`, and aborts a tile in progress. A pixel offered in the `start` cycle is ignored, and no entry is written in that cycle.
- R9: After reset and before the first `start`, no entry is written, `done` and `overflow` are low, and offered pixels are ignored.
- R10: Cycles with `flow_valid` low between pixels add nothing to the gap or the pixel count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new tile scan |
| threshold | input | FLOW_W+1 | Unsigned survival threshold |
| flow_valid | input | 1 | du/dv carry a pixel this cycle |
| flow_du | input | FLOW_W | Signed horizontal flow |
| flow_dv | input | FLOW_W | Signed vertical flow |
| map_we0 | output | 1 | Lane 0 (run-length entry) write enable |
| map_addr0 | output | clog2(MAP_DEPTH) | Lane 0 address |
| map_data0 | output | ENTRY_W | Lane 0 entry value |
| map_we1 | output | 1 | Lane 1 (row terminator) write enable |
| map_addr1 | output | clog2(MAP_DEPTH) | Lane 1 address |
| map_data1 | output | ENTRY_W | Lane 1 entry value (always 0) |
| done | output | 1 | One-cycle end-of-tile pulse |
| overflow | output | 1 | Map was too small for this tile |

## Verification
The bench builds the encoder with 8-bit flow, a 12 × 4 tile, a 24-entry map, 3-bit entries and the registered magnitude stage. With 3-bit entries, a single row with survivors only at its two ends already pushes a gap past the saturation point. A 24-entry map is overrun by one all-survivor tile, and the drop can land between the two lanes of one pixel. The 8-bit flow puts the most negative component and the exact threshold boundary within reach of both directed and seeded random tiles.

// File: rtl/bgd_pkg.sv
package bgd_pkg;

   // One classified pixel moving from the magnitude stage to the encoder.
   typedef struct packed {
      logic valid;     // a pixel of the current tile
      logic bg;        // magnitude below threshold
      logic row_end;   // last column of its row
      logic tile_end;  // last pixel of the tile
   } bgd_px_t;

endpackage

// File: rtl/bgd_scan.sv
// Raster position tracker: accepts pixels only while a tile is open.
module bgd_scan #(
   parameter int TILE_W = 30,
   parameter int TILE_H = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic flow_valid,
   output logic px_take,
   output logic row_end,
   output logic tile_end
);

   localparam int COL_W = $clog2(TILE_W + 1);
   localparam int ROW_W = $clog2(TILE_H + 1);

   logic             busy;
   logic [COL_W-1:0] col;
   logic [ROW_W-1:0] row;

   always_comb begin
      px_take  = busy & flow_valid & ~start;
      row_end  = (col == COL_W'(TILE_W - 1));
      tile_end = row_end & (row == ROW_W'(TILE_H - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         col  <= '0;
         row  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         col  <= '0;
         row  <= '0;
      end else if (px_take) begin
         if (row_end) begin
            col <= '0;
            if (tile_end) begin
               busy <= 1'b0;
               row  <= '0;
            end else begin
               row <= row + ROW_W'(1);
            end
         end else begin
            col <= col + COL_W'(1);
         end
      end
   end

   // R7: the tile closes once its last pixel is taken
   assert_stop_at_tile_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (px_take && tile_end) |=> !busy);

   // R9: before any start nothing is accepted
   assert_idle_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |-> !px_take);

endmodule

// File: rtl/bgd_mag.sv
// |du| + |dv| against threshold, combinational or registered.
module bgd_mag import bgd_pkg::*; #(
   parameter int FLOW_W    = 12,
   parameter int MAG_STAGE = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     take,
   input  logic                     row_end,
   input  logic                     tile_end,
   input  logic signed [FLOW_W-1:0] du,
   input  logic signed [FLOW_W-1:0] dv,
   input  logic        [FLOW_W:0]   thr,
   output bgd_px_t                  px
);

   localparam int MAG_W = FLOW_W + 1;

   logic [FLOW_W-1:0] adu, adv;
   logic [MAG_W-1:0]  mag;
   bgd_px_t           cur;

   always_comb begin
      adu = du[FLOW_W-1] ? (~unsigned'(du) + FLOW_W'(1)) : unsigned'(du);
      adv = dv[FLOW_W-1] ? (~unsigned'(dv) + FLOW_W'(1)) : unsigned'(dv);
      mag = {1'b0, adu} + {1'b0, adv};
      cur.valid    = take;
      cur.bg       = (mag < thr);
      cur.row_end  = row_end;
      cur.tile_end = tile_end;
   end

   generate
      if (MAG_STAGE == 0) begin : g_comb
         assign px = cur;
      end else begin : g_reg
         bgd_px_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= '0;
            else if (flush) q <= '0;
            else            q <= cur;
         end
         assign px = q;

         // R1: every accepted pixel reaches the encoder one edge later
         assert_stage_carries_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (take && !flush) |=> px.valid);
      end
   endgenerate

endmodule

// File: rtl/bgd_runlen.sv
// Gap counter, entry formation, write pointer and overflow guard.
module bgd_runlen import bgd_pkg::*; #(
   parameter int TILE_W    = 30,
   parameter int MAP_DEPTH = 320,
   parameter int ENTRY_W   = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  bgd_px_t                      px,
   output logic                         wr0_en,
   output logic [$clog2(MAP_DEPTH)-1:0] wr0_addr,
   output logic [ENTRY_W-1:0]           wr0_data,
   output logic                         wr1_en,
   output logic [$clog2(MAP_DEPTH)-1:0] wr1_addr,
   output logic [ENTRY_W-1:0]           wr1_data,
   output logic                         done,
   output logic                         overflow
);

   localparam int ADDR_W    = $clog2(MAP_DEPTH);
   localparam int PTR_W     = $clog2(MAP_DEPTH + 1);
   localparam int GAP_W     = $clog2(TILE_W + 1);
   localparam int ENTRY_MAX = (1 << ENTRY_W) - 1;

   logic [PTR_W-1:0]   ptr, room, addr1_full, ptr_nx;
   logic [GAP_W-1:0]   gap;
   logic [GAP_W:0]     gap_p1;
   logic [ENTRY_W-1:0] entry;
   logic               act, surv, mark, ok0, ok1, drop;

   always_comb begin
      act    = px.valid & ~start;
      surv   = act & ~px.bg;
      mark   = act & px.row_end;
      room   = PTR_W'(MAP_DEPTH) - ptr;
      ok0    = surv && (room != '0);
      ok1    = mark && (room > PTR_W'(surv));
      drop   = (surv & ~ok0) | (mark & ~ok1);
      gap_p1 = {1'b0, gap} + (GAP_W + 1)'(1);
      if (32'(gap_p1) > 32'(ENTRY_MAX)) entry = ENTRY_W'(ENTRY_MAX);
      else                              entry = ENTRY_W'(gap_p1);
      addr1_full = ptr + PTR_W'(ok0);
      ptr_nx     = addr1_full + PTR_W'(ok1);
   end

   assign wr0_en   = ok0;
   assign wr0_addr = ptr[ADDR_W-1:0];
   assign wr0_data = entry;
   assign wr1_en   = ok1;
   assign wr1_addr = addr1_full[ADDR_W-1:0];
   assign wr1_data = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         gap      <= '0;
         overflow <= 1'b0;
         done     <= 1'b0;
      end else if (start) begin
         ptr      <= '0;
         gap      <= '0;
         overflow <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= act & px.tile_end;
         if (act) begin
            ptr      <= ptr_nx;
            gap      <= (surv | mark) ? '0 : gap_p1[GAP_W-1:0];
            overflow <= overflow | drop;
         end
      end
   end

   // R3: a stored entry is never the terminator value
   assert_entry_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr0_en |-> (wr0_data != '0));

   // R3: the write pointer only advances between starts
   assert_ptr_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (ptr >= $past(ptr)));

   // R5: a terminator follows its pixel's entry directly
   assert_lanes_adjacent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0_en && wr1_en) |-> (wr1_addr == wr0_addr + ADDR_W'(1)));

   // R6: the pointer never passes the map depth
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PTR_W'(MAP_DEPTH));

   // R6: the overflow flag holds until a new tile
   assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !start) |=> overflow);

   // R8: start always clears the flag
   assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !overflow);

   // R7: done is a single-cycle pulse
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/bgd_dist_encoder.sv
module bgd_dist_encoder import bgd_pkg::*; #(
   parameter int FLOW_W    = 12,
   parameter int TILE_W    = 30,
   parameter int TILE_H    = 30,
   parameter int MAP_DEPTH = 320,
   parameter int ENTRY_W   = 8,
   parameter int MAG_STAGE = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [FLOW_W:0]              threshold,
   input  logic                         flow_valid,
   input  logic signed [FLOW_W-1:0]     flow_du,
   input  logic signed [FLOW_W-1:0]     flow_dv,
   output logic                         map_we0,
   output logic [$clog2(MAP_DEPTH)-1:0] map_addr0,
   output logic [ENTRY_W-1:0]           map_data0,
   output logic                         map_we1,
   output logic [$clog2(MAP_DEPTH)-1:0] map_addr1,
   output logic [ENTRY_W-1:0]           map_data1,
   output logic                         done,
   output logic                         overflow
);

   generate
      if (FLOW_W < 2)                      begin : g_bad_flow  $error("FLOW_W must be at least 2"); end
      if (TILE_W < 2)                      begin : g_bad_w     $error("TILE_W must be at least 2"); end
      if (TILE_H < 1)                      begin : g_bad_h     $error("TILE_H must be at least 1"); end
      if (MAP_DEPTH < 2)                   begin : g_bad_depth $error("MAP_DEPTH must be at least 2"); end
      if (ENTRY_W < 2 || ENTRY_W > 16)     begin : g_bad_entry $error("ENTRY_W out of range"); end
      if (MAG_STAGE != 0 && MAG_STAGE != 1) begin : g_bad_stage $error("MAG_STAGE must be 0 or 1"); end
   endgenerate

   logic    px_take, row_end, tile_end;
   bgd_px_t px;

   bgd_scan #(
      .TILE_W (TILE_W),
      .TILE_H (TILE_H)
   ) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .flow_valid (flow_valid),
      .px_take    (px_take),
      .row_end    (row_end),
      .tile_end   (tile_end)
   );

   bgd_mag #(
      .FLOW_W    (FLOW_W),
      .MAG_STAGE (MAG_STAGE)
   ) u_mag (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (start),
      .take     (px_take),
      .row_end  (row_end),
      .tile_end (tile_end),
      .du       (flow_du),
      .dv       (flow_dv),
      .thr      (threshold),
      .px       (px)
   );

   bgd_runlen #(
      .TILE_W    (TILE_W),
      .MAP_DEPTH (MAP_DEPTH),
      .ENTRY_W   (ENTRY_W)
   ) u_runlen (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .px       (px),
      .wr0_en   (map_we0),
      .wr0_addr (map_addr0),
      .wr0_data (map_data0),
      .wr1_en   (map_we1),
      .wr1_addr (map_addr1),
      .wr1_data (map_data1),
      .done     (done),
      .overflow (overflow)
   );

endmodule

// File: tb/bgd_dist_encoder_tb.sv
module bgd_dist_encoder_tb;

   localparam int FW    = 8;
   localparam int TW    = 12;
   localparam int TH    = 4;
   localparam int DEPTH = 24;
   localparam int EW    = 3;
   localparam int EMAX  = (1 << EW) - 1;
   localparam int NPX   = TW * TH;
   localparam int AW    = $clog2(DEPTH);

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 start = 1'b0;
   logic [FW:0]          thr = '0;
   logic                 fvalid = 1'b0;
   logic signed [FW-1:0] du = '0, dv = '0;
   logic                 we0, we1, done, ovf;
   logic [AW-1:0]        a0, a1;
   logic [EW-1:0]        d0, d1;

   always #2 clk = ~clk;

   bgd_dist_encoder #(
      .FLOW_W (FW), .TILE_W (TW), .TILE_H (TH),
      .MAP_DEPTH (DEPTH), .ENTRY_W (EW), .MAG_STAGE (1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .start (start), .threshold (thr),
      .flow_valid (fvalid), .flow_du (du), .flow_dv (dv),
      .map_we0 (we0), .map_addr0 (a0), .map_data0 (d0),
      .map_we1 (we1), .map_addr1 (a1), .map_data1 (d1),
      .done (done), .overflow (ovf)
   );

   int n_chk = 0, n_bad = 0;
   logic signed [FW-1:0] tdu [NPX];
   logic signed [FW-1:0] tdv [NPX];
   int exp_d [128];
   int exp_n;
   int log_a [256];
   int log_d [256];
   int log_n = 0;

   // write monitor, lane 0 before lane 1
   always @(negedge clk) begin
      if (rst_n) begin
         if (we0) begin
            if (log_n < 256) begin log_a[log_n] = int'(a0); log_d[log_n] = int'(d0); end
            log_n++;
         end
         if (we1) begin
            if (log_n < 256) begin log_a[log_n] = int'(a1); log_d[log_n] = int'(d1); end
            log_n++;
         end
      end
   end

   task automatic chk(input bit ok, input string what, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
      end
   endtask

   function automatic int absv(input logic signed [FW-1:0] x);
      int v = int'(x);
      return (v < 0) ? -v : v;
   endfunction

   // expected entry list from the requirements
   task automatic build_exp(input int t);
      int gap = 0;
      exp_n = 0;
      for (int p = 0; p < NPX; p++) begin
         int m = absv(tdu[p]) + absv(tdv[p]);
         if (m >= t) begin
            exp_d[exp_n++] = (gap + 1 > EMAX) ? EMAX : gap + 1;
            gap = 0;
         end else begin
            gap++;
         end
         if (p % TW == TW - 1) begin
            exp_d[exp_n++] = 0;
            gap = 0;
         end
      end
   endtask

   task automatic pulse_start(input int t);
      @(posedge clk); #1;
      start = 1'b1; thr = (FW+1)'(t); fvalid = 1'b0;
      @(posedge clk); #1;
      start = 1'b0;
      log_n = 0;
   endtask

   task automatic drive_px(input int p);
      fvalid = 1'b1; du = tdu[p]; dv = tdv[p];
      @(posedge clk); #1;
   endtask

   task automatic run_tile(input int t, input int idle_pct, input string tag);
      int keep, lim;
      build_exp(t);
      pulse_start(t);
      @(negedge clk);
      chk(ovf == 1'b0, {tag, " R8 overflow cleared by start"}, ovf, 0);
      @(posedge clk); #1;
      for (int p = 0; p < NPX; p++) begin
         if (idle_pct > 0 && int'($urandom_range(99)) < idle_pct) begin
            fvalid = 1'b0; du = 8'sd127; dv = 8'sd127;  // R10 idle cycle with live data
            repeat (1 + $urandom_range(1)) begin @(posedge clk); #1; end
         end
         drive_px(p);
      end
      fvalid = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, {tag, " R7 done not early"}, done, 0);
      @(negedge clk);
      chk(done == 1'b1, {tag, " R7 done on last store edge"}, done, 1);
      @(negedge clk);
      chk(done == 1'b0, {tag, " R7 done one cycle"}, done, 0);
      keep = (exp_n > DEPTH) ? DEPTH : exp_n;
      chk(log_n == keep, {tag, " R6 entry count"}, log_n, keep);
      chk(ovf == (exp_n > DEPTH), {tag, " R6 overflow flag"}, ovf, int'(exp_n > DEPTH));
      lim = (log_n < keep) ? log_n : keep;
      for (int i = 0; i < lim; i++) begin
         string kind;
         if (exp_d[i] == 0)         kind = "R5 row terminator";
         else if (exp_d[i] == EMAX) kind = "R4 saturated entry";
         else if (exp_d[i] > 1)     kind = "R2 gap entry";
         else                       kind = "R3 adjacent entry";
         chk(log_a[i] == i, {tag, " R3 address order"}, log_a[i], i);
         chk(log_d[i] == exp_d[i], {tag, " ", kind}, log_d[i], exp_d[i]);
      end
      // R7: pixels after the tile closes are ignored
      keep = log_n;
      @(posedge clk); #1;
      for (int k = 0; k < 3; k++) begin
         fvalid = 1'b1; du = 8'sd127; dv = -8'sd128;
         @(posedge clk); #1;
      end
      fvalid = 1'b0;
      repeat (3) @(negedge clk);
      chk(log_n == keep, {tag, " R7 no writes after done"}, log_n, keep);
      chk(done == 1'b0, {tag, " R7 no second done"}, done, 0);
   endtask

   task automatic fill_const(input int a, input int b);
      for (int p = 0; p < NPX; p++) begin tdu[p] = FW'(a); tdv[p] = FW'(b); end
   endtask

   task automatic fill_sparse();
      for (int p = 0; p < NPX; p++) begin
         if ($urandom_range(3) == 0) begin
            tdu[p] = FW'($urandom_range(255));
            tdv[p] = FW'($urandom_range(255));
         end else begin
            tdu[p] = FW'($urandom_range(4)) - FW'(2);
            tdv[p] = FW'($urandom_range(4)) - FW'(2);
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_0B6D));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9: reset state and pixels before any start
      repeat (2) @(negedge clk);
      chk(done == 1'b0, "R9 done low after reset", done, 0);
      chk(ovf == 1'b0, "R9 overflow low after reset", ovf, 0);
      @(posedge clk); #1;
      for (int k = 0; k < 5; k++) begin
         fvalid = 1'b1; du = -8'sd128; dv = -8'sd128;
         @(posedge clk); #1;
      end
      fvalid = 1'b0;
      repeat (3) @(negedge clk);
      chk(log_n == 0, "R9 no writes before start", log_n, 0);
      chk(done == 1'b0, "R9 no done before start", done, 0);

      // R1 + R6: threshold 0 keeps every pixel and overruns the map
      fill_const(0, 0);
      run_tile(0, 0, "R1 zero threshold");

      // R2: everything is background, only terminators remain
      fill_const(0, 0);
      run_tile(1, 0, "R2 all background");

      // R1: boundary magnitudes around threshold 100
      for (int p = 0; p < NPX; p++) begin
         case (p % 3)
            0:       begin tdu[p] = 8'sd50;   tdv[p] = -8'sd50;  end
            1:       begin tdu[p] = -8'sd99;  tdv[p] = 8'sd0;    end
            default: begin tdu[p] = -8'sd128; tdv[p] = -8'sd128; end
         endcase
      end
      run_tile(100, 0, "R1 boundary");

      // R1: most negative components against the top threshold value
      for (int p = 0; p < NPX; p++) begin
         if (p % 4 == 0) begin tdu[p] = -8'sd128; tdv[p] = -8'sd128; end
         else            begin tdu[p] = 8'sd127;  tdv[p] = 8'sd127;  end
      end
      run_tile(256, 0, "R1 most negative");

      // R4: survivors only at both row ends give a long gap
      for (int p = 0; p < NPX; p++) begin
         if (p % TW == 0 || p % TW == TW - 1) begin tdu[p] = 8'sd40; tdv[p] = 8'sd0; end
         else                                  begin tdu[p] = 8'sd1;  tdv[p] = -8'sd1; end
      end
      run_tile(10, 0, "R4 saturation");

      // R8: abort a tile halfway, then run a full one
      fill_const(0, 0);
      pulse_start(0);
      for (int p = 0; p < NPX / 2; p++) drive_px(p);
      fill_sparse();
      run_tile(8, 0, "R8 restart");

      // R10: seeded random tiles with idle cycles
      for (int r = 0; r < 6; r++) begin
         fill_sparse();
         run_tile(4 + 2 * r, 30, "R10 random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule